// File: doc/BRIEF.md
# Per-Core Local Tick Timer

This block is the timer that sits beside one processor core and produces its periodic or single-shot tick interrupt. A prescaler divides the block clock by a programmable amount. Each prescaler tick decrements an interrupt counter. When the counter expires it either reloads from its buffer and keeps firing (interval mode) or parks at zero after firing once (one-shot mode).

Software drives the block through a small 32-bit register window. It can program the prescaler divisor and the interrupt period, start and stop the two counters separately, and enable, observe and clear the interrupt. Every write to a configuration register is acknowledged through a sticky write-status bit. A write to the interrupt buffer only takes effect when bit 31 of the data is set. The live values of both counters can be read back.

Top module: `core_tick_timer`

## Requirements
- R1: After reset every register reads zero, both counters are zero and `irq` is low.
- R2: With control bit 0 set, the prescaler emits one tick every (D+1) clocks, where D is the divisor held at offset 0x00. A write to 0x00 restarts the prescaler count (read at 0x04) from zero.
- R3: A write to offset 0x08 with data bit 31 set loads bits 30:0 into both the reload buffer and the live counter (read at 0x0C). A write there with bit 31 clear changes neither of them.
- R4: The interrupt counter moves only on a prescaler tick while control bits 0 and 1 are both set. Control bit 0 alone runs the prescaler but leaves the interrupt counter unchanged.
- R5: With control bit 2 clear (one-shot), a counter loaded with N expires once, N ticks after start, then stays at zero with no further expiry.
- R6: With control bit 2 set (interval), the counter expires every N ticks and reloads N in the expiring tick.
- R7: Clearing the start bits freezes both counters at their current values. Setting them again resumes counting from those values.
- R8: Status bit 0 at offset 0x30 sets on an expiry only when enable bit 0 at offset 0x34 is set. Writing one to it clears it, but a simultaneous expiry wins. `irq` mirrors the status bit.
- R9: The write-status register at 0x40 sets bit 0 on a write to 0x00, bit 1 on a write to 0x08 (with or without bit 31) and bit 3 on a write to 0x20. Each bit is cleared by writing one to it, and a simultaneous new write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the prescaler input |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for one clock |
| bus_addr | input | 8 | Byte offset within the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt, equal to status bit 0 |

## Verification
The central sweep tries every divisor from 0 to 3 against every period from 1 to 4, in both one-shot and interval mode. During the sweep the status clear is held asserted, so each expiry appears as a single-cycle pulse. The pulse positions then separate an off-by-one in the prescaler (wrong spacing scaled by D+1) from one in the reload (wrong spacing in N), and a missing one-shot stop (extra pulses). Directed cases cover a non-qualified buffer write, the enable gate, a halt and resume with frozen counter values, and prescaler-only running. They also cover the write-status set and clear order.

// File: rtl/core_tick_timer.sv
`timescale 1ns/1ps
module core_tick_timer #(
  parameter int PRESC_W = 8,
  parameter int CNT_W   = 31
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  localparam logic [7:0] A_DIV  = 8'h00;
  localparam logic [7:0] A_PCUR = 8'h04;
  localparam logic [7:0] A_PER  = 8'h08;
  localparam logic [7:0] A_ICUR = 8'h0C;
  localparam logic [7:0] A_CTL  = 8'h20;
  localparam logic [7:0] A_STS  = 8'h30;
  localparam logic [7:0] A_IEN  = 8'h34;
  localparam logic [7:0] A_ACK  = 8'h40;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [PRESC_W-1:0] div_q, pcnt_q;
  logic [CNT_W-1:0]   per_q, icnt_q;
  logic [2:0]         ctl_q;
  logic               sts_q, ien_q;
  logic               ack_div_q, ack_per_q, ack_ctl_q;

  logic wr_div, wr_per, wr_ctl, wr_sts, wr_ien, wr_ack;
  logic load, tick, step, expire;
  logic unused_bits;

  assign wr_div = bus_wr && bus_addr == A_DIV;
  assign wr_per = bus_wr && bus_addr == A_PER;
  assign wr_ctl = bus_wr && bus_addr == A_CTL;
  assign wr_sts = bus_wr && bus_addr == A_STS;
  assign wr_ien = bus_wr && bus_addr == A_IEN;
  assign wr_ack = bus_wr && bus_addr == A_ACK;

  assign load   = wr_per && bus_wdata[31];
  assign tick   = ctl_q[0] && pcnt_q == div_q;
  assign step   = tick && ctl_q[1] && !load;
  assign expire = step && icnt_q == ONE;
  assign unused_bits = ^bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pcnt_q <= '0;
    else if (wr_div)   pcnt_q <= '0;
    else if (ctl_q[0]) pcnt_q <= tick ? '0 : pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      icnt_q <= '0;
      per_q  <= '0;
    end else if (load) begin
      icnt_q <= bus_wdata[CNT_W-1:0];
      per_q  <= bus_wdata[CNT_W-1:0];
    end else if (step && icnt_q != '0) begin
      if (icnt_q == ONE) icnt_q <= ctl_q[2] ? per_q : '0;
      else               icnt_q <= icnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      ctl_q <= '0;
      ien_q <= 1'b0;
      sts_q <= 1'b0;
      ack_div_q <= 1'b0;
      ack_per_q <= 1'b0;
      ack_ctl_q <= 1'b0;
    end else begin
      if (wr_div) div_q <= bus_wdata[PRESC_W-1:0];
      if (wr_ctl) ctl_q <= bus_wdata[2:0];
      if (wr_ien) ien_q <= bus_wdata[0];
      if (expire && ien_q)            sts_q <= 1'b1;
      else if (wr_sts && bus_wdata[0]) sts_q <= 1'b0;
      if (wr_div)                      ack_div_q <= 1'b1;
      else if (wr_ack && bus_wdata[0]) ack_div_q <= 1'b0;
      if (wr_per)                      ack_per_q <= 1'b1;
      else if (wr_ack && bus_wdata[1]) ack_per_q <= 1'b0;
      if (wr_ctl)                      ack_ctl_q <= 1'b1;
      else if (wr_ack && bus_wdata[3]) ack_ctl_q <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr)
      A_DIV:   bus_rdata = 32'(div_q);
      A_PCUR:  bus_rdata = 32'(pcnt_q);
      A_PER:   bus_rdata = 32'(per_q);
      A_ICUR:  bus_rdata = 32'(icnt_q);
      A_CTL:   bus_rdata = {29'd0, ctl_q};
      A_STS:   bus_rdata = {31'd0, sts_q};
      A_IEN:   bus_rdata = {31'd0, ien_q};
      A_ACK:   bus_rdata = {28'd0, ack_ctl_q, 1'b0, ack_per_q, ack_div_q};
      default: bus_rdata = '0;
    endcase
  end

  assign irq = sts_q;

  assert_presc_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q <= div_q);
  assert_count_within_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    icnt_q <= per_q);
  assert_frozen_when_stopped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q[0] && !load) |=> $stable(icnt_q));
  assert_prescaler_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q[1] && !load) |=> $stable(icnt_q));
  assert_oneshot_parks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (icnt_q == '0 && !load) |=> icnt_q == '0);
  assert_status_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q) |-> $past(ien_q));
  assert_ack_on_ctl_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> ack_ctl_q);
endmodule

// File: tb/sim_core_tick_timer.sv
`timescale 1ns/1ps
module sim_core_tick_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic irq;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  core_tick_timer u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
                      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog got=hung exp=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, v1, p1;
    idle(2);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    for (int k = 0; k < 9; k++) begin
      rd(8'(k * 4) + ((k > 4) ? 8'h0C : 8'h00), v);
      chk("R1 reg", v, 0);
    end
    chk("R1 irq", {31'd0, irq}, 0);

    // R2 R5 R6 sweep: held status clear turns each expiry into a one-cycle pulse
    for (int mode = 0; mode < 2; mode++)
      for (int t = 0; t < 4; t++)
        for (int n = 1; n < 5; n++) begin
          int p, bad;
          p = n * (t + 1);
          bad = 0;
          wr(8'h20, 0);
          wr(8'h00, t);
          wr(8'h08, 32'h8000_0000 | n);
          wr(8'h34, 1);
          wr(8'h30, 1);
          wr(8'h20, mode ? 7 : 3);
          bus_wr = 1'b1; bus_addr = 8'h30; bus_wdata = 1;
          for (int c = 1; c <= 4 * p; c++) begin
            logic e;
            @(posedge clk); #1;
            e = mode ? (c % p == 0) : (c == p);
            if (irq !== e) bad++;
          end
          bus_wr = 1'b0;
          chk(mode ? "R6 R2 R8 interval pulses" : "R5 R2 R8 one-shot pulses", bad, 0);
          rd(8'h0C, v);
          chk(mode ? "R6 reloaded count" : "R5 parked count", v, mode ? n : 0);
        end

    // R3 unqualified write leaves buffer and counter alone, R9 still acked
    wr(8'h20, 0);
    wr(8'h08, 32'h8000_0009);
    wr(8'h40, 32'hF);
    wr(8'h08, 32'h0000_0005);
    rd(8'h08, v); chk("R3 buffer kept", v, 9);
    rd(8'h0C, v); chk("R3 counter kept", v, 9);
    rd(8'h40, v); chk("R9 ack on unqualified write", v, 32'h2);

    // R9 set and clear sequence
    wr(8'h40, 32'hF);
    wr(8'h00, 3);
    rd(8'h40, v); chk("R9 div ack", v, 32'h1);
    wr(8'h20, 0);
    rd(8'h40, v); chk("R9 ctl ack", v, 32'h9);
    wr(8'h40, 32'h1);
    rd(8'h40, v); chk("R9 clear bit0", v, 32'h8);
    wr(8'h40, 32'h8);
    rd(8'h40, v); chk("R9 clear bit3", v, 32'h0);

    // R8 enable gate
    wr(8'h34, 0);
    wr(8'h30, 1);
    wr(8'h00, 0);
    wr(8'h08, 32'h8000_0001);
    wr(8'h20, 3);
    idle(6);
    rd(8'h30, v); chk("R8 gated status", v, 0);
    chk("R8 gated irq", {31'd0, irq}, 0);
    rd(8'h0C, v); chk("R5 expired while gated", v, 0);

    // R7 halt and resume
    wr(8'h20, 0);
    wr(8'h00, 3);
    rd(8'h04, v); chk("R2 div write restarts prescaler", v, 0);
    wr(8'h08, 32'h8000_0064);
    wr(8'h20, 7);
    idle(21);
    wr(8'h20, 0);
    rd(8'h0C, v1);
    rd(8'h04, p1);
    chk("R7 counter moved", {31'd0, v1 < 100}, 1);
    idle(12);
    rd(8'h0C, v); chk("R7 counter frozen", v, v1);
    rd(8'h04, v); chk("R7 prescaler frozen", v, p1);
    wr(8'h20, 7);
    idle(12);
    rd(8'h0C, v); chk("R7 resumed", {31'd0, v < v1}, 1);

    // R4 prescaler only
    wr(8'h20, 1);
    rd(8'h0C, v1);
    idle(16);
    rd(8'h0C, v); chk("R4 counter held", v, v1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule